// File: doc/BRIEF.md
# Couplet Turbo Interleaver

This block reorders a frame of two-bit couplets for the second constituent encoder of a rate-1/3 duo-binary turbo encoder. The host loads couplets into an internal frame buffer in natural order through a simple write port. It then sets the frame length and the permutation constants and pulses `start`. The block fetches the couplets in interleaved order, one per clock. For each output position j it reads the natural couplet at (P·j + Q + 3) mod N. Q takes one of four values selected by j mod 4. On every odd output position the two bits of the couplet are exchanged.

No divider or multiplier sits on the per-couplet path. Output positions that share a residue class step through the frame by a constant 4·P mod N, so the block keeps four running addresses. Each one advances with an add followed by a conditional subtract. The four starting addresses and the step are computed once per frame, right after `start`, by a short add-and-reduce sequence. The terms that would otherwise need multiplication, such as Q0·P mod N, are built up by repeated modular addition. The frame length must be a multiple of 4 and at least 16. P must be below N and coprime to it. Each Q constant must be below N.

Top module: `couplet_interleaver`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are all low.
- R2: The couplet encoding is A in bit 1 and B in bit 0. For an even output position j, `out_data` equals the couplet stored at natural address (P·j + Q + 3) mod N. Q is 0 when j mod 4 = 0, 4·Q1 when j mod 4 = 1, 4·Q0·P + 4·Q2 when j mod 4 = 2, and 4·Q0·P + 4·Q3 when j mod 4 = 3.
- R3: For an odd output position j, `out_data` is the couplet at the same address as in R2 with its two bits exchanged, so A appears in bit 0 and B in bit 1.
- R4: A frame produces exactly N outputs. Their `out_idx` values run 0, 1, …, N-1 on consecutive `out_valid` cycles, and the natural addresses read form a permutation of 0..N-1.
- R5: `done` is high for exactly one cycle. That cycle is the one right after the `out_valid` cycle with `out_idx` = N-1, and `busy` is low in it.
- R6: A `start` pulse while `busy` is high is ignored. The running frame continues unchanged and no further outputs follow its `done`.
- R7: Writes presented while `busy` is high do not change the frame buffer.
- R8: The length and constant inputs are captured when `start` is accepted. Changing them during a frame has no effect on that frame.
- R9: Consecutive frames with different lengths and constants each follow R2 to R5 with their own parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a couplet into the frame buffer (ignored while busy) |
| wr_addr | input | AW | Natural-order address of the written couplet |
| wr_data | input | 2 | Couplet, A in bit 1, B in bit 0 |
| cfg_len | input | AW+1 | Frame length N in couplets |
| cfg_p | input | AW+1 | Permutation constant P |
| cfg_q0 | input | QW | Permutation constant Q0 |
| cfg_q1 | input | QW | Permutation constant Q1 |
| cfg_q2 | input | QW | Permutation constant Q2 |
| cfg_q3 | input | QW | Permutation constant Q3 |
| start | input | 1 | Begin a frame (accepted only when idle) |
| busy | output | 1 | A frame is being set up or read out |
| out_valid | output | 1 | `out_data` and `out_idx` carry an interleaved couplet |
| out_idx | output | AW | Output position j of the couplet |
| out_data | output | 2 | Interleaved couplet, swapped on odd j |
| done | output | 1 | One-cycle pulse after the last couplet |

## Verification
The hardest condition to reach is one where the inputs change under a running frame: a second `start`, changed constants and buffer writes all arrive mid-frame. A correct design must ignore every one of them. The stimulus raises all three together a few dozen cycles into a short frame, during the offset set-up. It then reruns the same frame without reloading the buffer, so any overwritten couplet or restarted sequence shows up as a mismatch against the scoreboard. The three known-good constant sets include a zero Q0, a large Q0 and a frame near the buffer size. Together they drive the running addresses through many wrap-arounds in every residue class.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   // Control sequencer of the top level
   typedef enum logic [1:0] {
      CT_IDLE,
      CT_INIT,
      CT_RUN,
      CT_TAIL
   } ctl_st_t;

   // Offset set-up sequencer
   typedef enum logic [2:0] {
      OS_IDLE,
      OS_STEP,
      OS_RQ,
      OS_BASE,
      OS_X4,
      OS_XP
   } ofs_st_t;

   localparam int unsigned NUM_CLASS = 4;
   localparam int unsigned COUPLET_W = 2;
endpackage

// File: rtl/ilv_mod_add.sv
module ilv_mod_add #(
   parameter int unsigned W = 13
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] m,
   output logic [W-1:0] s
);
   // Both operands are below m, so one conditional subtract reduces the sum.
   logic [W:0] sum;
   assign sum = {1'b0, a} + {1'b0, b};
   assign s   = (sum >= {1'b0, m}) ? W'(sum - {1'b0, m}) : sum[W-1:0];
endmodule

// File: rtl/ilv_frame_buf.sv
module ilv_frame_buf #(
   parameter int unsigned DEPTH = 4096,
   parameter int unsigned DW    = 2,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/ilv_offset_init.sv
module ilv_offset_init
   import ilv_pkg::*;
#(
   parameter int unsigned NW = 13,
   parameter int unsigned QW = 4,
   localparam int unsigned CW = QW + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           go,
   input  logic [NW-1:0]                  n,
   input  logic [NW-1:0]                  p,
   input  logic [QW-1:0]                  q0,
   input  logic [QW-1:0]                  q1,
   input  logic [QW-1:0]                  q2,
   input  logic [QW-1:0]                  q3,
   output logic                           ready,
   output logic [NW-1:0]                  step,
   output logic [NUM_CLASS-1:0][NW-1:0]   offs
);
   ofs_st_t       st;
   logic [CW-1:0] cnt;
   logic [1:0]    cls;
   logic [NW-1:0] acc, rq, base;
   logic [NW-1:0] add_a, add_b, add_s, qsel;

   always_comb begin
      case (cls)
         2'd0:    qsel = '0;
         2'd1:    qsel = NW'(q1);
         2'd2:    qsel = NW'(q2);
         default: qsel = NW'(q3);
      endcase
   end

   // One shared modular adder; its operands depend on the phase.
   always_comb begin
      add_a = acc;
      add_b = '0;
      case (st)
         OS_STEP, OS_RQ: add_b = p;
         OS_BASE: begin
            add_a = cls[1] ? rq : '0;
            add_b = qsel;
         end
         OS_X4:   add_b = base;
         OS_XP:   add_b = (cnt == CW'(cls)) ? NW'(3) : p;
         default: add_b = '0;
      endcase
   end

   ilv_mod_add #(.W(NW)) i_add (.a(add_a), .b(add_b), .m(n), .s(add_s));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= OS_IDLE;
         cnt   <= '0;
         cls   <= '0;
         acc   <= '0;
         rq    <= '0;
         base  <= '0;
         step  <= '0;
         offs  <= '0;
         ready <= 1'b0;
      end else begin
         ready <= 1'b0;
         case (st)
            OS_IDLE: if (go) begin
               acc <= '0;
               cnt <= '0;
               st  <= OS_STEP;
            end
            OS_STEP: if (cnt == CW'(4)) begin      // step = 4P mod N
               step <= acc;
               acc  <= '0;
               cnt  <= '0;
               st   <= OS_RQ;
            end else begin
               acc <= add_s;
               cnt <= cnt + 1'b1;
            end
            OS_RQ: if (cnt == CW'(q0)) begin       // rq = Q0*P mod N
               rq  <= acc;
               cls <= '0;
               st  <= OS_BASE;
            end else begin
               acc <= add_s;
               cnt <= cnt + 1'b1;
            end
            OS_BASE: begin                          // class base term
               base <= add_s;
               acc  <= '0;
               cnt  <= '0;
               st   <= OS_X4;
            end
            OS_X4: if (cnt == CW'(4)) begin         // 4 * base
               cnt <= '0;
               st  <= OS_XP;
            end else begin
               acc <= add_s;
               cnt <= cnt + 1'b1;
            end
            OS_XP: if (cnt == CW'(cls)) begin       // + c*P, then + 3
               offs[cls] <= add_s;
               if (cls == 2'd3) begin
                  ready <= 1'b1;
                  st    <= OS_IDLE;
               end else begin
                  cls <= cls + 1'b1;
                  st  <= OS_BASE;
               end
            end else begin
               acc <= add_s;
               cnt <= cnt + 1'b1;
            end
            default: st <= OS_IDLE;
         endcase
      end
   end

   // R2
   offs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (offs[0] < n && offs[1] < n && offs[2] < n && offs[3] < n && step < n));

   // R5
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
   import ilv_pkg::*;
#(
   parameter int unsigned NW = 13,
   localparam int unsigned AW = NW - 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         adv,
   input  logic [NW-1:0]                n,
   input  logic [NW-1:0]                step,
   input  logic [NUM_CLASS-1:0][NW-1:0] offs,
   output logic [AW-1:0]                addr,
   output logic [AW-1:0]                idx,
   output logic                         last
);
   logic [NUM_CLASS-1:0][NW-1:0] cur, nxt;

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
      ilv_mod_add #(.W(NW)) i_step (.a(cur[c]), .b(step), .m(n), .s(nxt[c]));

      always_ff @(posedge clk) begin
         if (!rst_n)                       cur[c] <= '0;
         else if (load)                    cur[c] <= offs[c];
         else if (adv && idx[1:0] == 2'(c)) cur[c] <= nxt[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= '0;
      else if (adv)  idx <= idx + 1'b1;
   end

   assign addr = cur[idx[1:0]][AW-1:0];
   assign last = ({1'b0, idx} == n - NW'(1));

   // R4
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> cur[idx[1:0]] < n);
endmodule

// File: rtl/couplet_interleaver.sv
module couplet_interleaver
   import ilv_pkg::*;
#(
   parameter int unsigned MAX_N = 4096,
   parameter int unsigned QW    = 4,
   localparam int unsigned AW   = $clog2(MAX_N),
   localparam int unsigned NW   = AW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [COUPLET_W-1:0] wr_data,
   input  logic [NW-1:0]        cfg_len,
   input  logic [NW-1:0]        cfg_p,
   input  logic [QW-1:0]        cfg_q0,
   input  logic [QW-1:0]        cfg_q1,
   input  logic [QW-1:0]        cfg_q2,
   input  logic [QW-1:0]        cfg_q3,
   input  logic                 start,
   output logic                 busy,
   output logic                 out_valid,
   output logic [AW-1:0]        out_idx,
   output logic [COUPLET_W-1:0] out_data,
   output logic                 done
);
   if (MAX_N < 16 || (MAX_N % 4) != 0 || (1 << AW) != MAX_N) begin : g_bad_depth
      $error("MAX_N must be a power of two of at least 16");
   end
   if (QW < 1 || (1 << QW) > 16) begin : g_bad_qw
      $error("QW must keep the Q constants below the minimum frame length");
   end

   ctl_st_t              st;
   logic [NW-1:0]        n_q, p_q;
   logic [QW-1:0]        q0_q, q1_q, q2_q, q3_q;
   logic                 go, ready, rd_en, last;
   logic [NW-1:0]        step;
   logic [NUM_CLASS-1:0][NW-1:0] offs;
   logic [AW-1:0]        rd_addr, idx;
   logic [COUPLET_W-1:0] rd_data;
   logic                 vld_q, done_q;
   logic [AW-1:0]        idx_q;

   assign go    = (st == CT_IDLE) && start;
   assign rd_en = (st == CT_RUN);
   assign busy  = (st != CT_IDLE);

   ilv_frame_buf #(.DEPTH(MAX_N), .DW(COUPLET_W)) i_buf (
      .clk, .rst_n,
      .wr_en(wr_en && !busy), .wr_addr, .wr_data,
      .rd_en, .rd_addr, .rd_data
   );

   ilv_offset_init #(.NW(NW), .QW(QW)) i_init (
      .clk, .rst_n, .go,
      .n(n_q), .p(p_q), .q0(q0_q), .q1(q1_q), .q2(q2_q), .q3(q3_q),
      .ready, .step, .offs
   );

   ilv_addr_gen #(.NW(NW)) i_agen (
      .clk, .rst_n, .load(ready), .adv(rd_en),
      .n(n_q), .step, .offs,
      .addr(rd_addr), .idx, .last
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= CT_IDLE;
         n_q    <= '0;
         p_q    <= '0;
         q0_q   <= '0;
         q1_q   <= '0;
         q2_q   <= '0;
         q3_q   <= '0;
         vld_q  <= 1'b0;
         idx_q  <= '0;
         done_q <= 1'b0;
      end else begin
         case (st)
            CT_IDLE: if (start) begin
               n_q  <= cfg_len;
               p_q  <= cfg_p;
               q0_q <= cfg_q0;
               q1_q <= cfg_q1;
               q2_q <= cfg_q2;
               q3_q <= cfg_q3;
               st   <= CT_INIT;
            end
            CT_INIT: if (ready) st <= CT_RUN;
            CT_RUN:  if (last)  st <= CT_TAIL;
            default: st <= CT_IDLE;
         endcase
         vld_q <= rd_en;
         if (rd_en) idx_q <= idx;
         done_q <= vld_q && ({1'b0, idx_q} == n_q - NW'(1));
      end
   end

   assign out_valid = vld_q;
   assign out_idx   = idx_q;
   assign out_data  = idx_q[0] ? {rd_data[0], rd_data[1]} : rd_data;
   assign done      = done_q;

   // R5
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(out_valid) && !busy));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> out_idx == $past(out_idx) + 1'b1);

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st != CT_INIT) |=> st != CT_INIT);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(n_q) && $stable(p_q));
endmodule

// File: tb/test_couplet_interleaver.sv
`timescale 1ns/1ps
module test_couplet_interleaver;
   localparam int MAX_N = 4096;
   localparam int QW    = 4;
   localparam int AW    = $clog2(MAX_N);
   localparam int NW    = AW + 1;

   typedef struct {
      int         idx;
      logic [1:0] data;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [1:0]    wr_data = '0;
   logic [NW-1:0] cfg_len = '0, cfg_p = '0;
   logic [QW-1:0] cfg_q0 = '0, cfg_q1 = '0, cfg_q2 = '0, cfg_q3 = '0;
   logic          start = 1'b0;
   logic          busy, out_valid, done;
   logic [AW-1:0] out_idx;
   logic [1:0]    out_data;

   int   errors = 0;
   int   checks = 0;
   exp_t sb[$];
   logic [1:0] mirror [MAX_N];
   int   exp_n = 0;
   int   done_cnt = 0;
   logic prev_vld = 1'b0;
   int   prev_idx = 0;
   logic prev_done = 1'b0;

   always #2.5 clk = ~clk;

   couplet_interleaver #(.MAX_N(MAX_N), .QW(QW)) i_couplet_interleaver (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .cfg_len, .cfg_p, .cfg_q0, .cfg_q1, .cfg_q2, .cfg_q3,
      .start, .busy, .out_valid, .out_idx, .out_data, .done
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ref_addr(int n, int p, int q0, int q1, int q2, int q3, int j);
      int q;
      case (j % 4)
         0: q = 0;
         1: q = 4 * q1;
         2: q = 4 * q0 * p + 4 * q2;
         default: q = 4 * q0 * p + 4 * q3;
      endcase
      return (p * j + q + 3) % n;
   endfunction

   task automatic write_couplet(input int a, input logic [1:0] d, input bit track);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      if (track) mirror[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Driver: fills the buffer, pushes expected couplets, starts the frame.
   task automatic run_frame(input int n, input int p, input int q0, input int q1,
                            input int q2, input int q3, input bit reload, input bit disturb);
      int  dups;
      int  start_done;
      bit  seen [MAX_N];
      if (reload)
         for (int a = 0; a < n; a++) write_couplet(a, 2'($urandom_range(0, 3)), 1'b1);
      dups = 0;
      for (int a = 0; a < n; a++) seen[a] = 1'b0;
      for (int j = 0; j < n; j++) begin
         int   a;
         exp_t e;
         a = ref_addr(n, p, q0, q1, q2, q3, j);
         if (seen[a]) dups++;
         seen[a] = 1'b1;
         e.idx  = j;
         e.data = (j % 2 == 1) ? {mirror[a][0], mirror[a][1]} : mirror[a];
         sb.push_back(e);
      end
      // R4: the reference addresses form a permutation
      check(dups == 0, "R4 permutation", dups, 0);
      exp_n      = n;
      start_done = done_cnt;
      @(negedge clk);
      cfg_len = NW'(n);
      cfg_p   = NW'(p);
      cfg_q0  = QW'(q0);
      cfg_q1  = QW'(q1);
      cfg_q2  = QW'(q2);
      cfg_q3  = QW'(q3);
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         repeat (30) @(negedge clk);
         check(busy == 1'b1, "R6 busy before restart attempt", int'(busy), 1);
         // R6 restart, R8 changed constants, R7 writes, all mid-frame
         start   = 1'b1;
         cfg_len = NW'(16);
         cfg_p   = NW'(3);
         cfg_q0  = QW'(5);
         cfg_q1  = QW'(1);
         for (int a = 0; a < 8; a++) begin
            wr_en   = 1'b1;
            wr_addr = AW'(a);
            wr_data = ~mirror[a];
            @(negedge clk);
         end
         wr_en = 1'b0;
         start = 1'b0;
      end
      while (done_cnt == start_done) @(negedge clk);
      // R4: exactly N outputs were produced
      check(sb.size() == 0, "R4 output count", sb.size(), 0);
      repeat (20) @(negedge clk);
      // R6: no further activity after done
      check(busy == 1'b0, "R6 idle after frame", int'(busy), 0);
   endtask

   // Monitor: compares outputs against the scoreboard away from the edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R6 unexpected output", int'(out_idx), -1);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(int'(out_idx) == e.idx, "R4 output index", int'(out_idx), e.idx);
               if (e.idx % 2 == 1)
                  check(out_data == e.data, "R3 odd couplet swapped", int'(out_data), int'(e.data));
               else
                  check(out_data == e.data, "R2 even couplet", int'(out_data), int'(e.data));
            end
         end
         if (done) begin
            check(prev_vld && prev_idx == exp_n - 1, "R5 done after last", prev_idx, exp_n - 1);
            check(busy == 1'b0, "R5 busy low with done", int'(busy), 0);
            check(!prev_done, "R5 done single cycle", int'(prev_done), 0);
            done_cnt++;
         end
         prev_vld  = out_valid;
         prev_idx  = int'(out_idx);
         prev_done = done;
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1 busy", int'(busy), 0);
      check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
      check(done == 1'b0, "R1 done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // Frame 1: disturbed by restart, constant change and writes (R6, R7, R8)
      run_frame(56, 9, 2, 2, 8, 0, 1'b1, 1'b1);
      // Frame 2: same buffer, not reloaded; mid-frame writes must not show (R7)
      run_frame(56, 9, 2, 2, 8, 0, 1'b0, 1'b0);
      // R9: back-to-back frames with different constants
      run_frame(776, 39, 7, 0, 0, 0, 1'b1, 1'b0);
      run_frame(2396, 81, 1, 2, 5, 2, 1'b1, 1'b0);
      run_frame(56, 9, 0, 0, 0, 0, 1'b1, 1'b0);
      check(done_cnt == 5, "R9 frame count", done_cnt, 5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule